// File: doc/BRIEF.md
# Logarithmic Barrel Shifter

This block shifts or rotates a data word by any distance from zero up to one less than the word width, in one pass of combinational logic. One input selects the operation: shift left with zero fill, shift right with zero fill, shift right with sign fill, or rotate right. The word moves through a ladder of fixed-distance multiplexer stages. Stage k moves the word by 2^k places when bit k of the amount is set, and passes it through unchanged when that bit is clear. A 32-bit word therefore needs five stages.

Left shifts reuse the right-shift ladder. The word is bit-reversed on the way in and again on the way out. The only difference between the right-going operations is what each stage feeds into the positions it vacates: zeros, copies of the original sign bit, or the bits that fell off the low end.

The block has no clock and holds no state. It is meant to sit inside an execute stage next to an adder, and the surrounding pipeline registers its output.

Top module: `barrel_shift_log`

## Requirements
- R1: With operation code 2'b00 (left logical), the result is the input shifted toward the most significant bit by the amount, and every vacated low position is 0.
- R2: With operation code 2'b01 (right logical), the result is the input shifted toward the least significant bit by the amount, and every vacated high position is 0.
- R3: With operation code 2'b10 (right arithmetic), the result is the input shifted right by the amount, and every vacated high position holds a copy of input bit WIDTH-1.
- R4: With operation code 2'b11 (rotate right), bit i of the result equals input bit (i + amount) mod WIDTH, so no bit is lost and none is created.
- R5: An amount of 0 gives a result equal to the input under every operation code.
- R6: Every amount from 0 through WIDTH-1 (31 at the default width) is honoured exactly, including the largest, which leaves a single original bit in a shift.
- R7: The result depends only on the present inputs. It holds no state between input changes and settles within the same time step as the inputs that caused it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word to be shifted or rotated |
| amt_i | input | $clog2(WIDTH) | Shift or rotate distance, unsigned |
| op_i | input | 2 | Operation code: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| result_o | output | WIDTH | Shifted or rotated word |

## Verification
Every result is due zero cycles after its inputs change, because no register lies between any input and the output. The bench applies each input set, waits one nanosecond so the combinational network can settle, and compares the output in that window, well before the next input change. The sweep covers every amount under every operation code, using patterned and pseudo-random words. Expected values come from the language's own shift operators and from a rotate formed by doubling the word.

// File: rtl/barrel_shift_pkg.sv
// Package barrel_shift_pkg
// Holds the types shared by the shifter and its stages: the external
// operation code and the internal per-stage fill selection.
// Assumes nothing about the width; widths are parameters of the modules.
package barrel_shift_pkg;

    // External operation code; the values are part of the port contract.
    typedef enum logic [1:0] {
        OP_SHL_LOGIC = 2'b00,
        OP_SHR_LOGIC = 2'b01,
        OP_SHR_ARITH = 2'b10,
        OP_ROT_RIGHT = 2'b11
    } shift_op_e;

    // What a right-going stage places into the positions it vacates.
    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_SIGN = 2'b01,
        FILL_WRAP = 2'b10
    } fill_mode_e;

endpackage

// File: rtl/bit_mirror.sv
// Module bit_mirror
// Reverses the bit order of a word: output bit i takes input bit WIDTH-1-i.
// Used twice around the right-shift ladder to turn it into a left shifter.
// Assumes WIDTH >= 1. Pure wiring, no logic.
module bit_mirror #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    // One wire per bit, crossing the word end to end.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = din[WIDTH-1-i];
    end

endmodule

// File: rtl/shr_stage.sv
// Module shr_stage
// One fixed-distance level of the logarithmic ladder. When en_i is set, the
// word moves DIST places toward bit 0. The top DIST positions are then filled
// according to mode_i: zeros, the sign bit, or the bits that left the bottom.
// When en_i is clear, the word passes through unchanged.
// Assumes 0 < DIST < WIDTH.
module shr_stage
    import barrel_shift_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] din,
    input  logic             en_i,
    input  fill_mode_e       mode_i,
    input  logic             sign_i,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] moved;

    // Build the moved word. The lower positions take their neighbour DIST
    // places up; the vacated upper positions take the fill selected by mode_i.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pos
        if (i + DIST < WIDTH) begin : g_body
            assign moved[i] = din[i+DIST];
        end else begin : g_fill
            assign moved[i] = (mode_i == FILL_WRAP) ? din[i+DIST-WIDTH] :
                              (mode_i == FILL_SIGN) ? sign_i : 1'b0;
        end
    end

    // 2-to-1 choice between the moved word and the untouched word.
    assign dout = en_i ? moved : din;

endmodule

// File: rtl/barrel_shift_log.sv
// Module barrel_shift_log
// Combinational shifter and rotator. A ladder of $clog2(WIDTH) fixed-distance
// stages is controlled bit-for-bit by the amount. A left shift mirrors the word
// before and after the ladder. Assumes WIDTH is a power of two, at least 2.
// No clock and no reset: there is no state to initialise.
module barrel_shift_log
    import barrel_shift_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]         data_i,
    input  logic [$clog2(WIDTH)-1:0] amt_i,
    input  logic [1:0]               op_i,
    output logic [WIDTH-1:0]         result_o
);

    localparam int LEVELS = $clog2(WIDTH);

    shift_op_e        op;
    fill_mode_e       fill;
    logic             go_left;
    logic             sign_bit;
    logic [WIDTH-1:0] mirrored_in;
    logic [WIDTH-1:0] mirrored_out;
    logic [WIDTH-1:0] level [0:LEVELS];

    assign op       = shift_op_e'(op_i);
    assign go_left  = (op == OP_SHL_LOGIC);
    assign sign_bit = data_i[WIDTH-1];

    // Pick the vacated-position fill from the operation code.
    always_comb begin
        case (op)
            OP_SHR_ARITH: fill = FILL_SIGN;
            OP_ROT_RIGHT: fill = FILL_WRAP;
            default:      fill = FILL_ZERO;
        endcase
    end

    bit_mirror #(.WIDTH(WIDTH)) u_mirror_in (
        .din  (data_i),
        .dout (mirrored_in)
    );

    // Feed the ladder: the mirrored word for a left shift, the word itself otherwise.
    assign level[0] = go_left ? mirrored_in : data_i;

    // One stage per amount bit; stage k moves the word by 2^k places.
    for (genvar k = 0; k < LEVELS; k++) begin : g_level
        shr_stage #(
            .WIDTH (WIDTH),
            .DIST  (1 << k)
        ) u_stage (
            .din    (level[k]),
            .en_i   (amt_i[k]),
            .mode_i (fill),
            .sign_i (sign_bit),
            .dout   (level[k+1])
        );
    end

    bit_mirror #(.WIDTH(WIDTH)) u_mirror_out (
        .din  (level[LEVELS]),
        .dout (mirrored_out)
    );

    // Undo the mirror for a left shift.
    assign result_o = go_left ? mirrored_out : level[LEVELS];

endmodule

// File: rtl/barrel_shift_log_chk.sv
// Module barrel_shift_log_chk
// Port-level checks on the shifter, bound to every instance of it. The block
// is combinational, so the checks are immediate assertions re-evaluated
// whenever an input or the result changes.
module barrel_shift_log_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0]         data_i,
    input logic [$clog2(WIDTH)-1:0] amt_i,
    input logic [1:0]               op_i,
    input logic [WIDTH-1:0]         result_o
);

    logic [WIDTH-1:0] keep_hi;
    logic [WIDTH-1:0] keep_lo;

    assign keep_hi = {WIDTH{1'b1}} << amt_i;
    assign keep_lo = {WIDTH{1'b1}} >> amt_i;

    // Re-check the port relations after every change on the ports.
    always_comb begin
        assert_zero_pass_R5: assert (amt_i != '0 || result_o == data_i)
            else $error("R5: zero amount altered the word");
        assert_left_zero_fill_R1: assert (op_i != 2'b00 || (result_o & ~keep_hi) == '0)
            else $error("R1: left shift brought in a one");
        assert_right_zero_fill_R2: assert (op_i != 2'b01 || (result_o & ~keep_lo) == '0)
            else $error("R2: right logical shift brought in a one");
        assert_sign_kept_R3: assert (op_i != 2'b10 || result_o[WIDTH-1] == data_i[WIDTH-1])
            else $error("R3: arithmetic shift lost the sign");
        assert_rotate_keeps_bits_R4: assert (op_i != 2'b11 || $countones(result_o) == $countones(data_i))
            else $error("R4: rotate changed the number of ones");
        assert_shift_no_new_ones_R6: assert (op_i[1] || $countones(result_o) <= $countones(data_i))
            else $error("R6: logical shift created ones");
    end

endmodule

bind barrel_shift_log barrel_shift_log_chk #(.WIDTH(WIDTH)) u_chk (
    .data_i   (data_i),
    .amt_i    (amt_i),
    .op_i     (op_i),
    .result_o (result_o)
);

// File: tb/tb_barrel_shift_log.sv
// Bench tb_barrel_shift_log
// Sweeps every amount under every operation code over patterned and
// pseudo-random words. It compares the result with expected values built from
// the language's shift operators. A free-running clock drives only the watchdog.
module tb_barrel_shift_log;

    localparam int W  = 32;
    localparam int AW = $clog2(W);

    logic          clk;
    logic          rst_n;
    logic [W-1:0]  data;
    logic [AW-1:0] amt;
    logic [1:0]    op;
    logic [W-1:0]  result;

    int checks;
    int errors;
    int cycles;
    bit finished;

    barrel_shift_log #(.WIDTH(W)) dut (
        .data_i   (data),
        .amt_i    (amt),
        .op_i     (op),
        .result_o (result)
    );

    // 250 MHz clock, used only for the watchdog count.
    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Watchdog: a hung run is counted as a failure and still reports.
    always @(posedge clk) begin
        if (!rst_n) cycles <= 0;
        else begin
            cycles <= cycles + 1;
            if (cycles > 150000 && !finished) begin
                errors = errors + 1;
                $display("FAIL watchdog: run exceeded cycle limit got %0d expected < 150000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    // Compare one result; prints FAIL only on a mismatch.
    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: op=%b amt=%0d data=%h got %h expected %h", req, op, amt, data, got, exp);
        end
    endtask

    // Apply one input set, let it settle, then check against the expectation.
    task automatic run_one(input logic [W-1:0] d, input int a, input logic [1:0] o);
        logic [W-1:0]   exp;
        logic [2*W-1:0] dbl;
        data = d;
        amt  = AW'(a);
        op   = o;
        #1;
        dbl = {d, d} >> a;
        case (o)
            2'b00:   exp = d << a;
            2'b01:   exp = d >> a;
            2'b10:   exp = W'($signed(d) >>> a);
            default: exp = dbl[W-1:0];
        endcase
        if (a == 0)           check("R5 zero amount", result, d);
        else if (a == W-1)    check("R6 largest amount", result, exp);
        else if (o == 2'b00)  check("R1 left logical", result, exp);
        else if (o == 2'b01)  check("R2 right logical", result, exp);
        else if (o == 2'b10)  check("R3 right arithmetic", result, exp);
        else                  check("R4 rotate right", result, exp);
        #1;
    endtask

    initial begin
        logic [W-1:0] seed_word;
        checks   = 0;
        errors   = 0;
        finished = 0;
        rst_n    = 1'b0;
        data     = '0;
        amt      = '0;
        op       = 2'b00;
        #1;
        // R7: no state, so the output follows the inputs at once, from the start.
        check("R7 idle output", result, '0);
        #9;
        rst_n = 1'b1;

        // R7: a change after a nonzero result is reflected immediately.
        data = 32'h8000_0001; amt = 5'd1; op = 2'b11; #1;
        check("R7 immediate response", result, 32'hC000_0000);
        data = 32'h0000_00F0; #1;
        check("R7 no held state", result, 32'h0000_0078);

        // Boundary words, including the sign bit set and clear.
        seed_word = 32'h1357_9BDF;
        for (int p = 0; p < 40; p++) begin
            logic [W-1:0] d;
            case (p)
                0:       d = 32'h0000_0000;
                1:       d = 32'hFFFF_FFFF;
                2:       d = 32'h8000_0000;
                3:       d = 32'h0000_0001;
                4:       d = 32'hAAAA_AAAA;
                5:       d = 32'h5555_5555;
                6:       d = 32'h7FFF_FFFF;
                default: begin
                    seed_word = seed_word * 32'd1664525 + 32'd1013904223;
                    d = seed_word ^ {seed_word[15:0], seed_word[31:16]};
                end
            endcase
            for (int o = 0; o < 4; o++) begin
                for (int a = 0; a < W; a++) begin
                    run_one(d, a, 2'(o));
                end
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule